// File: doc/BRIEF.md
# Upper-Memory Access Attribute Decoder

This block sits beside the CPU address path of a PC-class memory controller and decides, for each 16 KB segment of the first megabyte of address space, where a read and where a write are steered: to on-board DRAM, to the external expansion bus, or to the boot ROM chip select. Software programs the decision through a byte-wide indexed register file. One strobe loads an index and another strobe writes the data byte to the register that the index selects. The read data for the current index is always presented on `rdata`.

The routing result is combinational. The neighbouring address logic drives the segment number taken from CPU address bits 19:14, together with a per-segment flag vector that marks segments currently taken over by expanded-memory paging or a memory card. The block returns one 2-bit target for a read and one for a write. The fixed priority is: remap or expansion-bus claim first, then the paging flag, then the per-region shadow code.

Top module: `umr_decode_top`

## Requirements
- R1: After reset, with all configuration registers zero and the expansion-bus boundary not yet armed, segments 0–39 route reads and writes internal (01), segments 40–55 route both external (00), and segments 56–63 route both to ROM chip select (10). Index 0 reads 0xD6.
- R2: Index 0x00 always reads 0xD6 and index 0x01 always reads 0x00. Writes to either index, or to any index above 0x16, are dropped. Any index above 0x16 reads 0xFF.
- R3: A data strobe while the index is within 0x02..0x16 stores the byte. The byte reads back from the next cycle onward. An index strobe loads the index register.
- R4: Each region has a 2-bit shadow code. Bit 1 set routes reads internal and bit 0 set routes writes internal. A clear bit routes that access external, or to ROM chip select when the segment carries ROM select.
- R5: Shadow codes are packed lowest pair first. Index 0x0E holds one code per segment pair 40/41, 42/43, 44/45 and 46/47. Index 0x0F holds one code per segment 48..51. Index 0x10 holds one code per segment 52..55. Index 0x11 holds one code per segment pair 56/57, 58/59, 60/61 and 62/63.
- R6: When bit 4 of index 0x03 is set, segments 40–63 route both accesses external (ROM select where it applies), whatever their shadow code is. Segments 0–39 are unaffected.
- R7: The expansion-bus claim and the remap override the paging flag. The paging flag (`page_flags` bit = segment) routes both accesses internal and overrides the shadow code.
- R8: Bits 6:5 of index 0x03 place ROM chip select. Value 0 selects segments 56–59, value 1 selects none, value 2 selects segments 48, 49, 58 and 59, and value 3 selects segments 48–51. Segments 60–63 always carry ROM select.
- R9: Once index 0x02 has been written with value v, and v shifted left by 16 lies below 0xA0000, segments from 4·v through 39 route both accesses external. A value of 10 or more, which is clamped to 0x100000 or 0xFE0000, claims no segment of the first megabyte.
- R10: Each target is coded as 00 for external, 01 for internal and 10 for ROM chip select. The code 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Load `wdata` into the index register |
| data_wr | input | 1 | Write `wdata` to the indexed register |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte at the current index |
| page_flags | input | 64 | Per-segment paging or memory-card claim |
| seg_sel | input | 6 | Segment number (address bits 19:14) |
| rd_target | output | 2 | Read destination |
| wr_target | output | 2 | Write destination |

## Verification
The hardest condition to reach is a segment on which several sources of routing disagree at once: remap on, a non-zero shadow code, the paging flag and ROM select all on the same segment. Only that combination shows whether the priority order and the ROM substitution hold. The stimulus table programs all six steering registers for every row and can raise the paging flag on exactly the probed segment. Rows with conflicting sources are therefore placed directly next to rows that differ in a single field. A separate directed step leaves the expansion-bus boundary unarmed after reset and then arms it with zero, to show that the first write changes the low segments.

// File: rtl/umr_pkg.sv
package umr_pkg;

  localparam logic [1:0] TGT_EXT = 2'b00;
  localparam logic [1:0] TGT_INT = 2'b01;
  localparam logic [1:0] TGT_ROM = 2'b10;

  localparam logic [7:0] IDX_SLOT = 8'h02;
  localparam logic [7:0] IDX_MAP  = 8'h03;
  localparam logic [7:0] IDX_AB   = 8'h0E;
  localparam logic [7:0] IDX_C    = 8'h0F;
  localparam logic [7:0] IDX_D    = 8'h10;
  localparam logic [7:0] IDX_EF   = 8'h11;

  typedef struct packed {
    logic       remap;
    logic       slot;
    logic       page;
    logic       rom;
    logic [1:0] code;
  } seg_attr_t;

  // 2-bit shadow code of a segment; low 640 KB is plain internal DRAM
  function automatic logic [1:0] shadow_code(input int seg, input logic [7:0] map,
                                             input logic [7:0] ab, input logic [7:0] c,
                                             input logic [7:0] d, input logic [7:0] ef);
    logic [7:0] src;
    logic [7:0] sh;
    int pair;
    if (seg < 40) return 2'b11;
    if (map[4]) return 2'b00;
    if (seg < 48) begin src = ab; pair = (seg - 40) / 2; end
    else if (seg < 52) begin src = c; pair = seg - 48; end
    else if (seg < 56) begin src = d; pair = seg - 52; end
    else begin src = ef; pair = (seg - 56) / 2; end
    sh = src >> (2 * pair);
    return sh[1:0];
  endfunction

  function automatic logic rom_sel(input int seg, input logic [7:0] map);
    if (seg >= 60) return 1'b1;
    case (map[6:5])
      2'd0:    return (seg >= 56 && seg <= 59);
      2'd2:    return (seg == 48 || seg == 49 || seg == 58 || seg == 59);
      2'd3:    return (seg >= 48 && seg <= 51);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [23:0] slot_bound(input logic [7:0] v);
    logic [23:0] b;
    b = {v, 16'h0000};
    if (b >= 24'h0A0000 && b < 24'h100000) b = 24'h100000;
    if (b > 24'hFE0000) b = 24'hFE0000;
    return b;
  endfunction

  function automatic logic slot_hit(input int seg, input logic [7:0] v, input logic armed);
    logic [23:0] b;
    b = slot_bound(v);
    return armed && (seg < 40) && (b < 24'h0A0000) && (seg >= int'(b >> 14));
  endfunction

  // returns {read_target, write_target}
  function automatic logic [3:0] route(input seg_attr_t a);
    logic [1:0] outside;
    outside = a.rom ? TGT_ROM : TGT_EXT;
    if (a.remap || a.slot) return {outside, outside};
    if (a.page) return {TGT_INT, TGT_INT};
    return {(a.code[1] ? TGT_INT : outside), (a.code[0] ? TGT_INT : outside)};
  endfunction

endpackage

// File: rtl/umr_cfg_regs.sv
module umr_cfg_regs
  import umr_pkg::*;
#(
  parameter int         LO_IDX  = 2,
  parameter int         HI_IDX  = 22,
  parameter logic [7:0] CHIP_ID = 8'hD6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [7:0] slot_q,
  output logic [7:0] map_q,
  output logic [7:0] ab_q,
  output logic [7:0] c_q,
  output logic [7:0] d_q,
  output logic [7:0] ef_q,
  output logic       slot_armed
);
  localparam logic [7:0] LO_B = 8'(LO_IDX);
  localparam logic [7:0] HI_B = 8'(HI_IDX);

  logic [7:0] idx_q;
  logic [7:0] regs_q [LO_IDX:HI_IDX];
  logic       in_rng;
  logic       wr_hit;

  assign in_rng = (idx_q >= LO_B) && (idx_q <= HI_B);
  assign wr_hit = data_wr && in_rng;

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= 8'h00;
    else if (idx_wr) idx_q <= wdata;
  end

  for (genvar g = LO_IDX; g <= HI_IDX; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) regs_q[g] <= 8'h00;
      else if (data_wr && idx_q == 8'(g)) regs_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) slot_armed <= 1'b0;
    else if (data_wr && idx_q == IDX_SLOT) slot_armed <= 1'b1;
  end

  always_comb begin
    rdata = 8'hFF;
    if (idx_q == 8'h00) rdata = CHIP_ID;
    else if (idx_q == 8'h01) rdata = 8'h00;
    else begin
      for (int i = LO_IDX; i <= HI_IDX; i++)
        if (idx_q == 8'(i)) rdata = regs_q[i];
    end
  end

  assign slot_q = regs_q[int'(IDX_SLOT)];
  assign map_q  = regs_q[int'(IDX_MAP)];
  assign ab_q   = regs_q[int'(IDX_AB)];
  assign c_q    = regs_q[int'(IDX_C)];
  assign d_q    = regs_q[int'(IDX_D)];
  assign ef_q   = regs_q[int'(IDX_EF)];

  p_chip_id_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == 8'h00) |-> (rdata == CHIP_ID));
  p_oob_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q > HI_B) |-> (rdata == 8'hFF));
  p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !idx_wr) |=> (rdata == $past(wdata)));
  p_index_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && wdata == 8'h00) |=> (rdata == CHIP_ID));
endmodule

// File: rtl/umr_seg_attr.sv
module umr_seg_attr
  import umr_pkg::*;
#(
  parameter int NSEG = 64
) (
  input  logic [7:0]      slot_q,
  input  logic [7:0]      map_q,
  input  logic [7:0]      ab_q,
  input  logic [7:0]      c_q,
  input  logic [7:0]      d_q,
  input  logic [7:0]      ef_q,
  input  logic            slot_armed,
  input  logic [NSEG-1:0] page_flags,
  output seg_attr_t       attr [NSEG]
);
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_comb begin
      attr[g].remap = map_q[4] && (g >= 40);
      attr[g].slot  = slot_hit(g, slot_q, slot_armed);
      attr[g].page  = page_flags[g];
      attr[g].rom   = rom_sel(g, map_q);
      attr[g].code  = shadow_code(g, map_q, ab_q, c_q, d_q, ef_q);
    end
  end
endmodule

// File: rtl/umr_route.sv
module umr_route
  import umr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  seg_attr_t a,
  output logic [1:0] rd_target,
  output logic [1:0] wr_target
);
  logic [3:0] both;
  assign both      = route(a);
  assign rd_target = both[3:2];
  assign wr_target = both[1:0];

  p_code_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_target != 2'b11) && (wr_target != 2'b11));
  p_page_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (a.page && !a.remap && !a.slot) |-> (rd_target == TGT_INT && wr_target == TGT_INT));
  p_claim_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (a.slot || a.remap) |-> (rd_target == wr_target && rd_target != TGT_INT));
  p_read_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!a.page && !a.remap && !a.slot && a.code[1]) |-> (rd_target == TGT_INT));
endmodule

// File: rtl/umr_decode_top.sv
module umr_decode_top
  import umr_pkg::*;
#(
  parameter int         ADDR_W    = 20,
  parameter int         SEG_SHIFT = 14,
  parameter logic [7:0] CHIP_ID   = 8'hD6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          idx_wr,
  input  logic                          data_wr,
  input  logic [7:0]                    wdata,
  output logic [7:0]                    rdata,
  input  logic [(1<<(ADDR_W-SEG_SHIFT))-1:0] page_flags,
  input  logic [ADDR_W-SEG_SHIFT-1:0]   seg_sel,
  output logic [1:0]                    rd_target,
  output logic [1:0]                    wr_target
);
  localparam int SEG_W = ADDR_W - SEG_SHIFT;
  localparam int NSEG  = 1 << SEG_W;

  logic [7:0] slot_q, map_q, ab_q, c_q, d_q, ef_q;
  logic       slot_armed;
  seg_attr_t  attr [NSEG];
  seg_attr_t  cur;

  umr_cfg_regs #(.LO_IDX(2), .HI_IDX(22), .CHIP_ID(CHIP_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr), .wdata(wdata),
    .rdata(rdata), .slot_q(slot_q), .map_q(map_q), .ab_q(ab_q), .c_q(c_q),
    .d_q(d_q), .ef_q(ef_q), .slot_armed(slot_armed)
  );

  umr_seg_attr #(.NSEG(NSEG)) u_attr (
    .slot_q(slot_q), .map_q(map_q), .ab_q(ab_q), .c_q(c_q), .d_q(d_q), .ef_q(ef_q),
    .slot_armed(slot_armed), .page_flags(page_flags), .attr(attr)
  );

  assign cur = attr[seg_sel];

  umr_route u_route (
    .clk(clk), .rst_n(rst_n), .a(cur), .rd_target(rd_target), .wr_target(wr_target)
  );

  p_remap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (map_q[4] && seg_sel >= SEG_W'(40)) |-> (rd_target != TGT_INT && wr_target != TGT_INT));
  p_top_rom_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_sel >= SEG_W'(60)) |-> (rd_target != TGT_EXT && wr_target != TGT_EXT));
  p_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_armed && slot_q < 8'd10 && seg_sel < SEG_W'(40) &&
     {2'b00, seg_sel} >= {slot_q[5:0], 2'b00}) |-> (rd_target == TGT_EXT && wr_target == TGT_EXT));
endmodule

// File: tb/test_umr_decode_top.sv
`timescale 1ns/1ps
module test_umr_decode_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_wr = 1'b0;
  logic        data_wr = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [63:0] page_flags = 64'd0;
  logic [5:0]  seg_sel = 6'd0;
  logic [1:0]  rd_target, wr_target;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  umr_decode_top i_umr_decode_top (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr), .wdata(wdata),
    .rdata(rdata), .page_flags(page_flags), .seg_sel(seg_sel),
    .rd_target(rd_target), .wr_target(wr_target)
  );

  typedef struct packed {
    logic [7:0] slt, map, ab, c, d, ef;
    logic       pg;
    logic [5:0] seg;
    logic [1:0] rd, wr;
  } vec_t;

  // targets: 0 external, 1 internal, 2 ROM select
  localparam int NV = 29;
  localparam vec_t TBL [NV] = '{
    '{8'h10, 8'h20, 8'hE4, 8'h00, 8'h00, 8'h00, 1'b0, 6'd42, 2'd0, 2'd1}, // R4
    '{8'h10, 8'h20, 8'hE4, 8'h00, 8'h00, 8'h00, 1'b0, 6'd44, 2'd1, 2'd0}, // R4
    '{8'h10, 8'h20, 8'hE4, 8'h00, 8'h00, 8'h00, 1'b0, 6'd46, 2'd1, 2'd1}, // R5
    '{8'h10, 8'h20, 8'hE4, 8'h00, 8'h00, 8'h00, 1'b0, 6'd41, 2'd0, 2'd0}, // R5
    '{8'h10, 8'h00, 8'h00, 8'h1B, 8'h00, 8'h00, 1'b0, 6'd48, 2'd1, 2'd1}, // R5
    '{8'h10, 8'h00, 8'h00, 8'h1B, 8'h00, 8'h00, 1'b0, 6'd51, 2'd0, 2'd0}, // R8
    '{8'h10, 8'h60, 8'h00, 8'h1B, 8'h00, 8'h00, 1'b0, 6'd51, 2'd2, 2'd2}, // R8
    '{8'h10, 8'h60, 8'h00, 8'h1B, 8'h00, 8'h00, 1'b0, 6'd49, 2'd1, 2'd2}, // R8 R4
    '{8'h10, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 6'd58, 2'd2, 2'd2}, // R8
    '{8'h10, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 6'd56, 2'd0, 2'd0}, // R8
    '{8'h10, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 6'd50, 2'd0, 2'd0}, // R8
    '{8'h10, 8'h20, 8'h00, 8'h00, 8'h00, 8'h4E, 1'b0, 6'd57, 2'd1, 2'd0}, // R5
    '{8'h10, 8'h20, 8'h00, 8'h00, 8'h00, 8'h4E, 1'b0, 6'd61, 2'd2, 2'd2}, // R8
    '{8'h10, 8'h20, 8'h00, 8'h00, 8'h00, 8'h4E, 1'b0, 6'd63, 2'd2, 2'd1}, // R5 R4
    '{8'h10, 8'h30, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 6'd46, 2'd0, 2'd0}, // R6
    '{8'h10, 8'h30, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b1, 6'd46, 2'd0, 2'd0}, // R7
    '{8'h10, 8'h30, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0, 6'd62, 2'd2, 2'd2}, // R6
    '{8'h10, 8'h20, 8'h00, 8'h00, 8'h03, 8'h00, 1'b1, 6'd53, 2'd1, 2'd1}, // R7
    '{8'h10, 8'h20, 8'h00, 8'h00, 8'h03, 8'h00, 1'b0, 6'd52, 2'd1, 2'd1}, // R5
    '{8'h10, 8'h20, 8'h00, 8'h00, 8'h03, 8'h00, 1'b0, 6'd53, 2'd0, 2'd0}, // R5
    '{8'h05, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 6'd19, 2'd1, 2'd1}, // R9
    '{8'h05, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 6'd20, 2'd0, 2'd0}, // R9
    '{8'h05, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 6'd39, 2'd0, 2'd0}, // R9
    '{8'h05, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 6'd20, 2'd0, 2'd0}, // R7
    '{8'h09, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 6'd35, 2'd1, 2'd1}, // R9
    '{8'h09, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 6'd36, 2'd0, 2'd0}, // R9
    '{8'h0A, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 6'd39, 2'd1, 2'd1}, // R9
    '{8'h10, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 6'd10, 2'd1, 2'd1}, // R7
    '{8'h10, 8'h30, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 6'd39, 2'd1, 2'd1}  // R6
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic put_idx(input logic [7:0] v);
    @(negedge clk); idx_wr = 1'b1; wdata = v;
    @(negedge clk); idx_wr = 1'b0;
  endtask

  task automatic put_dat(input logic [7:0] v);
    @(negedge clk); data_wr = 1'b1; wdata = v;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] v);
    put_idx(i); put_dat(v);
  endtask

  task automatic probe(input string tag, input logic [5:0] s, input logic pg,
                       input logic [1:0] er, input logic [1:0] ew);
    seg_sel = s;
    page_flags = pg ? (64'd1 << s) : 64'd0;
    #1;
    chk({tag, " read"},  {6'd0, rd_target}, {6'd0, er});
    chk({tag, " write"}, {6'd0, wr_target}, {6'd0, ew});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 id after reset", rdata, 8'hD6);
    probe("R1 seg0", 6'd0, 1'b0, 2'd1, 2'd1);
    probe("R1 seg5", 6'd5, 1'b0, 2'd1, 2'd1);
    probe("R1 seg45", 6'd45, 1'b0, 2'd0, 2'd0);
    probe("R1 seg56", 6'd56, 1'b0, 2'd2, 2'd2);
    probe("R1 seg60", 6'd60, 1'b0, 2'd2, 2'd2);
    // R2 read-only and out-of-range indices
    reg_wr(8'h00, 8'h12); #1; chk("R2 id write dropped", rdata, 8'hD6);
    reg_wr(8'h01, 8'h34); #1; chk("R2 index1 write dropped", rdata, 8'h00);
    reg_wr(8'h17, 8'h56); #1; chk("R2 above range", rdata, 8'hFF);
    put_idx(8'hC3); #1; chk("R2 far index", rdata, 8'hFF);
    // R3 storage at range edges
    reg_wr(8'h16, 8'h5A); #1; chk("R3 top index", rdata, 8'h5A);
    reg_wr(8'h04, 8'hA5); #1; chk("R3 plain index", rdata, 8'hA5);
    put_idx(8'h16); #1; chk("R3 top index kept", rdata, 8'h5A);
    // R9 arming: a zero pointer claims every low segment once written
    reg_wr(8'h02, 8'h00); #1; chk("R9 slot readback", rdata, 8'h00);
    probe("R9 armed seg5", 6'd5, 1'b0, 2'd0, 2'd0);
    probe("R9 armed seg39", 6'd39, 1'b0, 2'd0, 2'd0);
    // table walk: R4 R5 R6 R7 R8 R9 R10
    for (int k = 0; k < NV; k++) begin
      reg_wr(8'h02, TBL[k].slt);
      reg_wr(8'h03, TBL[k].map);
      reg_wr(8'h0E, TBL[k].ab);
      reg_wr(8'h0F, TBL[k].c);
      reg_wr(8'h10, TBL[k].d);
      reg_wr(8'h11, TBL[k].ef);
      probe($sformatf("R10 table row %0d", k), TBL[k].seg, TBL[k].pg, TBL[k].rd, TBL[k].wr);
    end
    // R3 readback of a routing register after the table
    put_idx(8'h11); #1; chk("R3 ef readback", rdata, 8'h00);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule